// File: doc/BRIEF.md
# Fail-Safe Watchdog Counter with NMI Request

This block is a lock-up guard built around one down-counter that runs in a single mode: it interrupts when it reaches terminal count. Software writes an initial count, which is taken into the counter on the next enabled tick. The counter then decrements by one on each enabled tick. Software that is still alive writes the count again before it runs out. If the countdown reaches zero, the counter output goes high, a sticky bit in an 8-bit status byte is set, and a non-maskable interrupt request goes high. Both stay set until software clears them on purpose.

The counter advances only on cycles where `tick_en` is high, so a slow timebase can drive it from a fast clock. A mode write path exists so that it matches a general timer's programming model. Whatever mode is requested, the counter stays in its one supported mode.

Top module: `wdt_nmi_top`

## Requirements
- R1: After synchronous reset, `count_val`, `cnt_out`, `nmi_req`, `status` and `mode_rb` are all zero. The counter holds its value through enabled ticks until the first count write.
- R2: A mode write (`wr_mode`) with any `mode_sel` value leaves `mode_rb` at 0, the terminal-count interrupt mode. It does not change the count or the outputs.
- R3: On the edge of a count write, `cnt_out` goes low. The written value is copied into `count_val` on the first later edge with `tick_en` high. A further count write before that copy replaces the pending value.
- R4: Once loaded, `count_val` drops by one on each edge with `tick_en` high. On the edge where it goes from 1 to 0, `cnt_out`, `status[7]` and `nmi_req` all go high.
- R5: A count write made before the terminal edge prevents the expiry. Repeated reloads keep `nmi_req` low indefinitely.
- R6: A `clr_stat` pulse clears `status[7]` and `nmi_req` on that edge.
- R7: `status[7]` and `nmi_req` remain set across later count writes and countdowns until `clr_stat`.
- R8: A written count of 0 expires after 65536 enabled ticks following the load tick.
- R9: On edges where `tick_en` is low, `count_val` does not change.
- R10: If a count write and the terminal tick fall on the same edge, the write wins. No expiry is recorded, and the count is held until the new load.
- R11: If `clr_stat` and an expiry fall on the same edge, the flag ends up set.
- R12: After expiry, the counter keeps decrementing and wraps from 0 to 65535. `cnt_out` stays high, and no further expiry occurs until the next count write. All status bits other than bit 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one pulse per counter period |
| wr_count | input | 1 | Initial-count write strobe |
| wr_data | input | 16 | Initial count value, 0 meaning 65536 |
| wr_mode | input | 1 | Mode write strobe |
| mode_sel | input | 3 | Requested mode (coerced to 0) |
| clr_stat | input | 1 | Clear strobe for the sticky flag |
| count_val | output | 16 | Current count |
| cnt_out | output | 1 | Counter output, high after terminal count |
| status | output | 8 | Status byte, bit 7 is the sticky expiry flag |
| nmi_req | output | 1 | Non-maskable interrupt request |
| mode_rb | output | 3 | Effective mode readback |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and the flag at bit 7 of an 8-bit status byte. With these values, a run from a written count of 0 to expiry takes 65536 enabled ticks, which fits inside the run, so the zero-means-full-range case is observed end to end. The same width makes the wrap after expiry visible at 65535. The randomised stretch mixes sparse ticks with writes, clears and mode writes. This exercises the same-edge collisions of write with terminal tick and of clear with expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_SPENT = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic load;
        logic dec;
        logic expire;
    } wd_ctl_s;

    localparam int          MODE_W    = 3;
    localparam logic [2:0]  ONLY_MODE = 3'd0;

    function automatic logic [MODE_W-1:0] coerce_mode(input logic [MODE_W-1:0] req);
        return (req == ONLY_MODE) ? req : ONLY_MODE;
    endfunction

    function automatic logic hits_one(input logic [31:0] v);
        return v == 32'd1;
    endfunction

endpackage

// File: rtl/wdt_seq.sv
module wdt_seq
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             wr_count,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] count_val,
    output wd_ctl_s          ctl,
    output logic [CNT_W-1:0] pend,
    output wd_state_e        state,
    output logic             term_out
);
    wd_state_e        state_q;
    logic [CNT_W-1:0] pend_q;
    logic             out_q;
    logic [31:0]      count_wide;

    assign count_wide = 32'(count_val);

    always_comb begin
        ctl.load   = !wr_count && tick_en && (state_q == ST_ARMED);
        ctl.dec    = !wr_count && tick_en &&
                     ((state_q == ST_RUN) || (state_q == ST_SPENT));
        ctl.expire = ctl.dec && (state_q == ST_RUN) && hits_one(count_wide);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            out_q   <= 1'b0;
        end else if (wr_count) begin
            state_q <= ST_ARMED;
            pend_q  <= wr_data;
            out_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_ARMED: if (ctl.load) state_q <= ST_RUN;
                ST_RUN: if (ctl.expire) begin
                    state_q <= ST_SPENT;
                    out_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign pend     = pend_q;
    assign state    = state_q;
    assign term_out = out_q;
endmodule

// File: rtl/wdt_cnt.sv
module wdt_cnt
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wd_ctl_s          ctl,
    input  logic [CNT_W-1:0] pend,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (ctl.load) begin
            count_q <= pend;
        end else if (ctl.dec) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/wdt_flag.sv
module wdt_flag #(
    parameter int STAT_W   = 8,
    parameter int STAT_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              expire,
    input  logic              clr,
    output logic [STAT_W-1:0] status,
    output logic              nmi
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    generate
        for (genvar i = 0; i < STAT_W; i++) begin : g_stat
            if (i == STAT_BIT) begin : g_live
                assign status[i] = flag_q;
            end else begin : g_zero
                assign status[i] = 1'b0;
            end
        end
    endgenerate

    assign nmi = flag_q;
endmodule

// File: rtl/wdt_nmi_top.sv
module wdt_nmi_top
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int STAT_W   = 8,
    parameter int STAT_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_count,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              wr_mode,
    input  logic [2:0]        mode_sel,
    input  logic              clr_stat,
    output logic [CNT_W-1:0]  count_val,
    output logic              cnt_out,
    output logic [STAT_W-1:0] status,
    output logic              nmi_req,
    output logic [2:0]        mode_rb
);
    wd_ctl_s          ctl;
    logic [CNT_W-1:0] pend;
    wd_state_e        seq_state;
    logic [2:0]       mode_q;

    wdt_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_count(wr_count),
        .wr_data(wr_data), .count_val(count_val), .ctl(ctl), .pend(pend),
        .state(seq_state), .term_out(cnt_out)
    );

    wdt_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .ctl(ctl), .pend(pend), .count(count_val)
    );

    wdt_flag #(.STAT_W(STAT_W), .STAT_BIT(STAT_BIT)) u_flag (
        .clk(clk), .rst(rst), .expire(ctl.expire), .clr(clr_stat),
        .status(status), .nmi(nmi_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= ONLY_MODE;
        end else if (wr_mode) begin
            mode_q <= coerce_mode(mode_sel);
        end
    end

    assign mode_rb = mode_q;
endmodule

// File: rtl/wdt_nmi_chk.sv
module wdt_nmi_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             wr_count,
    input logic             clr_stat,
    input logic [CNT_W-1:0] count_val,
    input logic             cnt_out,
    input logic             nmi_req,
    input wd_state_e        seq_state
);
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_IDLE) |=> $stable(count_val));

    a_r3_out_low_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_count |=> !cnt_out);

    a_r4_rise_on_terminal: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_req) |-> ($past(tick_en) && !$past(wr_count) &&
                            ($past(count_val) == CNT_W'(1))));

    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_stat && !(tick_en && !wr_count && seq_state == ST_RUN &&
                       count_val == CNT_W'(1))) |=> !nmi_req);

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !clr_stat) |=> nmi_req);

    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(count_val));
endmodule

bind wdt_nmi_top wdt_nmi_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_count(wr_count),
    .clr_stat(clr_stat), .count_val(count_val), .cnt_out(cnt_out),
    .nmi_req(nmi_req), .seq_state(seq_state)
);

// File: tb/sim_wdt_nmi_top.sv
module sim_wdt_nmi_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0, wr_count = 1'b0, wr_mode = 1'b0, clr_stat = 1'b0;
    logic [15:0] wr_data = '0;
    logic [2:0]  mode_sel = '0;
    logic [15:0] count_val;
    logic        cnt_out, nmi_req;
    logic [7:0]  status;
    logic [2:0]  mode_rb;

    int total = 0;
    int bad   = 0;

    // reference model state: 0 idle, 1 armed, 2 run, 3 spent
    int          m_st   = 0;
    logic [15:0] m_pend = '0;
    logic [15:0] m_cnt  = '0;
    logic        m_out  = 1'b0;
    logic        m_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_nmi_top u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_count(wr_count),
        .wr_data(wr_data), .wr_mode(wr_mode), .mode_sel(mode_sel),
        .clr_stat(clr_stat), .count_val(count_val), .cnt_out(cnt_out),
        .status(status), .nmi_req(nmi_req), .mode_rb(mode_rb)
    );

    function automatic logic [7:0] exp_status(input logic f);
        return {f, 7'b0};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "count_val", 32'(count_val), 32'(m_cnt));
        chk(tag, "cnt_out",   32'(cnt_out),   32'(m_out));
        chk(tag, "nmi_req",   32'(nmi_req),   32'(m_flag));
        chk(tag, "status",    32'(status),    32'(exp_status(m_flag)));
        chk(tag, "mode_rb",   32'(mode_rb),   32'd0);
    endtask

    task automatic model(input logic wc, input logic [15:0] wd,
                         input logic tk, input logic clr);
        logic ex = 1'b0;
        if (wc) begin
            m_st = 1; m_pend = wd; m_out = 1'b0;
        end else if (tk) begin
            case (m_st)
                1: begin m_cnt = m_pend; m_st = 2; end
                2: begin
                    if (m_cnt == 16'd1) begin ex = 1'b1; m_out = 1'b1; m_st = 3; end
                    m_cnt = m_cnt - 16'd1;
                end
                3: m_cnt = m_cnt - 16'd1;
                default: ;
            endcase
        end
        if (ex) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
    endtask

    task automatic step(input logic wc, input logic [15:0] wd, input logic tk,
                        input logic clr, input logic wm, input logic [2:0] ms,
                        input string tag);
        wr_count = wc; wr_data = wd; tick_en = tk; clr_stat = clr;
        wr_mode = wm; mode_sel = ms;
        @(posedge clk);
        model(wc, wd, tk, clr);
        #1;
        compare(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b1, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic write(input logic [15:0] v, input string tag);
        step(1'b1, v, 1'b0, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic clear(input string tag);
        step(1'b0, '0, 1'b0, 1'b1, 1'b0, '0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 compare("R1 reset");
        rst = 1'b0;
        ticks(5, "R1 idle");

        // R2: mode writes are coerced and leave counting alone
        step(1'b0, '0, 1'b0, 1'b0, 1'b1, 3'd3, "R2");
        step(1'b0, '0, 1'b1, 1'b0, 1'b1, 3'd5, "R2");

        // R3/R4: load 5, run to expiry; R12 wrap afterwards
        write(16'd9, "R3 first");
        write(16'd5, "R3 replace");
        ticks(5, "R4");
        chk("R4", "expired", 32'(nmi_req), 32'd0);
        ticks(1, "R4 terminal");
        chk("R4", "nmi_req", 32'(nmi_req), 32'd1);
        ticks(3, "R12 wrap");
        chk("R12", "count_val", 32'(count_val), 32'hFFFD);
        step(1'b0, '0, 1'b1, 1'b0, 1'b1, 3'd7, "R2 while running");

        clear("R6");
        chk("R6", "nmi_req", 32'(nmi_req), 32'd0);

        // R5: keep reloading
        for (int k = 0; k < 6; k++) begin
            write(16'd10, "R5");
            ticks(8, "R5");
        end
        chk("R5", "nmi_req", 32'(nmi_req), 32'd0);

        // R7: sticky across reload
        write(16'd2, "R7");
        ticks(3, "R7");
        write(16'd50, "R7");
        ticks(20, "R7");
        chk("R7", "nmi_req", 32'(nmi_req), 32'd1);
        clear("R7 clear");

        // R9: no tick, no change
        write(16'd4, "R9");
        ticks(2, "R9");
        for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R9");
        chk("R9", "count_val", 32'(count_val), 32'd3);

        // R10: write on the terminal tick wins
        write(16'd2, "R10");
        ticks(2, "R10");
        step(1'b1, 16'd7, 1'b1, 1'b0, 1'b0, '0, "R10 collide");
        chk("R10", "nmi_req", 32'(nmi_req), 32'd0);
        ticks(3, "R10");

        // R11: clear on the expiry edge keeps the flag
        write(16'd1, "R11");
        ticks(1, "R11 load");
        step(1'b0, '0, 1'b1, 1'b1, 1'b0, '0, "R11 collide");
        chk("R11", "nmi_req", 32'(nmi_req), 32'd1);
        clear("R11");

        // R8: zero means 65536
        write(16'd0, "R8");
        ticks(65536, "R8");
        chk("R8", "nmi_req", 32'(nmi_req), 32'd0);
        ticks(1, "R8 terminal");
        chk("R8", "nmi_req", 32'(nmi_req), 32'd1);
        clear("R8");

        // randomised mix
        for (int i = 0; i < 4000; i++) begin
            logic wc, tk, cl, wm;
            logic [15:0] wd;
            wc = ($urandom % 40) == 0;
            tk = ($urandom % 3) != 0;
            cl = ($urandom % 25) == 0;
            wm = ($urandom % 30) == 0;
            wd = 16'($urandom % 24);
            step(wc, wd, tk, cl, wm, 3'($urandom), "R4/R10/R11 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule